// File: doc/BRIEF.md
# Audio Interface Bit-Clock Generator

This block runs in master mode. It derives the bit-clock timing and the left/right frame clock for one serial audio direction from the master clock. Both the converter-input side and the converter-output side of a codec use their own instance. The block works entirely in the master-clock domain. It produces a one-cycle bit-clock strobe, which downstream serial shifters use as an enable. It also produces a frame clock and an error flag that reports settings which cannot be honoured.

The oversampling rate is chosen by a 3-bit code, with one of five frame lengths of 128 to 512 master-clock cycles. The bit-clock divide ratio follows the rate and the DSP-mode select. The word-length select is looked at only to reject DSP mode where the bit budget of a short frame is too small.

A small state machine holds the settings that are in force. Its states are LOAD, RUN and HALT:
- LOAD is the state after reset. On the next edge it captures the inputs and enters RUN, or HALT if the rate code is reserved.
- RUN steps a position counter through the frame. On the last cycle of the frame it captures the inputs again, then either restarts the frame in RUN or moves to HALT.
- HALT captures the inputs on every cycle and returns to RUN at position 0 as soon as the rate code is valid.

Top module: `bclkgen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released (LOAD), `bclk_stb`, `lrclk` and `cfg_err` are all 0.
- R2: With DSP mode off and rate code 000 (frame length 128) or 001 (frame length 192), `bclk_stb` is 1 at even frame positions and 0 at odd ones. This is a divide by 2.
- R3: With DSP mode off and rate code 010, 011 or 100 (frame lengths 256, 384, 512), `bclk_stb` is 1 only at frame positions that are multiples of 4. This is a divide by 4.
- R4: With DSP mode on and a legal combination, `bclk_stb` is 1 in every cycle of the frame.
- R5: Word-length codes are 00=16, 01=20, 10=24 and 11=32 bits. Two kinds of combination are illegal: DSP mode with rate 000 and a word-length code other than 00, and DSP mode with rate 001 and word-length code 11. An illegal combination drives `cfg_err` to 1 and falls back to the non-DSP behaviour of R2 and R6. Otherwise the word length has no effect, and `cfg_err` is 0 for every legal combination.
- R6: Each frame lasts exactly the frame length of its rate code, counted in master-clock cycles. With DSP mode off, `lrclk` is 0 for the first half of the frame and 1 for the second half.
- R7: With DSP mode on and a legal combination, `lrclk` is 1 only in the first cycle of each frame.
- R8: Rate codes 101, 110 and 111 are reserved. While one of them is in force, `cfg_err` is 1 and both `bclk_stb` and `lrclk` are 0. The inputs are captured on every cycle in this condition, and the first legal code starts a new frame at position 0 on the next cycle.
- R9: Outside the reserved condition, the inputs are captured only in the last cycle of a frame. A change at any other time does not alter the outputs until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| rate_sel | input | 3 | Oversampling rate code |
| dsp_sel | input | 1 | DSP-mode select |
| wlen_sel | input | 2 | Word-length code (00=16, 01=20, 10=24, 11=32) |
| bclk_stb | output | 1 | Bit-clock strobe, one master-clock cycle per bit period |
| lrclk | output | 1 | Frame clock |
| cfg_err | output | 1 | Illegal or reserved setting in force |

## Verification
The hardest situations to reach are the hand-overs: a setting that changes in the last cycle of a frame, one that changes in the cycle just before it, and a reserved code that is left exactly one cycle after it was entered. Long-held frames alone never show whether the capture point is off by one. So the random stimulus holds each setting for a random span of 1 to about 600 cycles, which places changes at every frame position, and it includes one-cycle reserved pulses. Directed segments cover each of the four illegal DSP pairs and the legal pairs next to them.

// File: rtl/bclkgen_pkg.sv
package bclkgen_pkg;

    localparam int MAX_FRAME = 512;
    localparam int CNT_W     = $clog2(MAX_FRAME);
    localparam int RATE_W    = 3;
    localparam int WLEN_W    = 2;
    localparam logic [RATE_W-1:0] LAST_RATE = 3'd4;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } state_t;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              dsp;
        logic              err;
    } cfg_t;

    function automatic logic [CNT_W:0] frame_len(input logic [RATE_W-1:0] r);
        logic [CNT_W:0] len;
        unique case (r)
            3'd0:    len = 10'd128;
            3'd1:    len = 10'd192;
            3'd2:    len = 10'd256;
            3'd3:    len = 10'd384;
            3'd4:    len = 10'd512;
            default: len = 10'd128;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/bclkgen_decode.sv
module bclkgen_decode
    import bclkgen_pkg::*;
(
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              dsp_sel,
    input  logic [WLEN_W-1:0] wlen_sel,
    output cfg_t              cfg
);
    logic reserved;
    logic too_long;

    always_comb begin
        reserved = (rate_sel > LAST_RATE);
        too_long = dsp_sel && (((rate_sel == 3'd0) && (wlen_sel != 2'd0)) ||
                               ((rate_sel == 3'd1) && (wlen_sel == 2'd3)));
        cfg.rate = rate_sel;
        cfg.dsp  = dsp_sel && !too_long && !reserved;
        cfg.err  = reserved || too_long;
    end
endmodule

// File: rtl/bclkgen_fsm.sv
module bclkgen_fsm
    import bclkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg_in,
    output state_t           st,
    output logic [CNT_W-1:0] pos,
    output cfg_t             act,
    output logic             frame_end
);
    state_t           st_nx;
    logic [CNT_W-1:0] pos_nx;
    cfg_t             act_nx;
    logic             take;

    always_comb begin
        frame_end = (st == ST_RUN) && ({1'b0, pos} == frame_len(act.rate) - 1'b1);
        take      = 1'b0;
        st_nx     = st;
        pos_nx    = pos;
        act_nx    = act;
        unique case (st)
            ST_LOAD: take = 1'b1;
            ST_RUN: begin
                if (frame_end) take = 1'b1;
                else           pos_nx = pos + 1'b1;
            end
            ST_HALT: take = 1'b1;
            default: take = 1'b1;
        endcase
        if (take) begin
            act_nx = cfg_in;
            pos_nx = '0;
            st_nx  = (cfg_in.rate > LAST_RATE) ? ST_HALT : ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_LOAD;
            pos <= '0;
            act <= '0;
        end else begin
            st  <= st_nx;
            pos <= pos_nx;
            act <= act_nx;
        end
    end
endmodule

// File: rtl/bclkgen_outmux.sv
module bclkgen_outmux
    import bclkgen_pkg::*;
(
    input  state_t           st,
    input  logic [CNT_W-1:0] pos,
    input  cfg_t             act,
    output logic             bclk_stb,
    output logic             lrclk,
    output logic             cfg_err
);
    logic [CNT_W:0] half;

    always_comb begin
        half     = frame_len(act.rate) >> 1;
        bclk_stb = 1'b0;
        lrclk    = 1'b0;
        cfg_err  = 1'b0;
        unique case (st)
            ST_RUN: begin
                cfg_err = act.err;
                if (act.dsp) begin
                    bclk_stb = 1'b1;
                    lrclk    = (pos == '0);
                end else begin
                    bclk_stb = (act.rate < 3'd2) ? !pos[0] : (pos[1:0] == 2'b00);
                    lrclk    = ({1'b0, pos} >= half);
                end
            end
            ST_HALT: cfg_err = 1'b1;
            ST_LOAD: cfg_err = 1'b0;
            default: cfg_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/bclkgen.sv
module bclkgen
    import bclkgen_pkg::*;
(
    input  logic              mclk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              dsp_sel,
    input  logic [WLEN_W-1:0] wlen_sel,
    output logic              bclk_stb,
    output logic              lrclk,
    output logic              cfg_err
);
    cfg_t             cfg_in;
    cfg_t             act;
    state_t           st;
    logic [CNT_W-1:0] pos;
    logic             frame_end;

    bclkgen_decode u_decode (
        .rate_sel (rate_sel),
        .dsp_sel  (dsp_sel),
        .wlen_sel (wlen_sel),
        .cfg      (cfg_in)
    );

    bclkgen_fsm u_fsm (
        .clk       (mclk),
        .rst_n     (rst_n),
        .cfg_in    (cfg_in),
        .st        (st),
        .pos       (pos),
        .act       (act),
        .frame_end (frame_end)
    );

    bclkgen_outmux u_outmux (
        .st       (st),
        .pos      (pos),
        .act      (act),
        .bclk_stb (bclk_stb),
        .lrclk    (lrclk),
        .cfg_err  (cfg_err)
    );
endmodule

// File: rtl/bclkgen_chk.sv
module bclkgen_chk
    import bclkgen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_stb,
    input logic             lrclk,
    input logic             cfg_err,
    input state_t           st,
    input logic [CNT_W-1:0] pos,
    input cfg_t             act,
    input logic             frame_end
);
    assert_load_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |-> (!bclk_stb && !lrclk && !cfg_err));

    assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_stb && st == ST_RUN && !act.dsp && act.rate < 3'd2) |=> !bclk_stb);

    assert_quarter_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_stb && st == ST_RUN && !act.dsp && act.rate >= 3'd2) |=> !bclk_stb);

    assert_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && bclk_stb) |=> !bclk_stb);

    assert_frame_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lrclk) && st == ST_RUN && !act.dsp) |-> (pos == '0));

    assert_dsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lrclk && st == ST_RUN && act.dsp) |=> !lrclk);

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> (cfg_err && !bclk_stb && !lrclk));

    assert_hold_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !frame_end) |=> $stable(act));
endmodule

bind bclkgen bclkgen_chk u_chk (
    .clk       (mclk),
    .rst_n     (rst_n),
    .bclk_stb  (bclk_stb),
    .lrclk     (lrclk),
    .cfg_err   (cfg_err),
    .st        (st),
    .pos       (pos),
    .act       (act),
    .frame_end (frame_end)
);

// File: tb/bclkgen_bench.sv
`timescale 1ns/1ps
module bclkgen_bench;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       dsp_sel = 1'b0;
    logic [1:0] wlen_sel = 2'd0;
    logic       bclk_stb, lrclk, cfg_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // model of the settings in force: 0 LOAD, 1 RUN, 2 HALT
    int m_st = 0;
    int m_pos = 0;
    int m_rate = 0;
    bit m_dsp = 0;
    bit m_err = 0;

    always #10 mclk = ~mclk;

    bclkgen u_bclkgen (
        .mclk(mclk), .rst_n(rst_n), .rate_sel(rate_sel), .dsp_sel(dsp_sel),
        .wlen_sel(wlen_sel), .bclk_stb(bclk_stb), .lrclk(lrclk), .cfg_err(cfg_err)
    );

    function automatic int ref_len(input int r);
        case (r)
            0: return 128;
            1: return 192;
            2: return 256;
            3: return 384;
            default: return 512;
        endcase
    endfunction

    function automatic bit ref_illegal(input int r, input bit d, input int w);
        return d && ((r == 0 && w != 0) || (r == 1 && w == 3));
    endfunction

    task automatic check(input string tag, input string what, input bit act_v, input bit exp_v);
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            if (n_fail < 30)
                $display("[TB] FAIL %s %s at %0t: actual %0b expected %0b", tag, what, $time, act_v, exp_v);
        end
    endtask

    always @(negedge mclk) begin
        if (!done) begin
            bit e_stb, e_lr, e_err;
            string tag;
            e_stb = 0; e_lr = 0; e_err = 0;
            if (!rst_n || m_st == 0) begin
                tag = "R1";
            end else if (m_st == 2) begin
                tag = "R8"; e_err = 1;
            end else begin
                e_err = m_err;
                if (m_dsp) begin
                    e_stb = 1; e_lr = (m_pos == 0);
                    tag = "R4/R7";
                end else begin
                    e_stb = (m_rate < 2) ? (m_pos % 2 == 0) : (m_pos % 4 == 0);
                    e_lr  = (m_pos >= ref_len(m_rate) / 2);
                    tag = m_err ? "R5" : ((m_rate < 2) ? "R2/R6" : "R3/R6");
                end
                if ((int'(rate_sel) != m_rate || dsp_sel != m_dsp) && m_pos != ref_len(m_rate) - 1)
                    tag = {tag, " R9"};
            end
            check(tag, "bclk_stb", bclk_stb, e_stb);
            check(tag, "lrclk", lrclk, e_lr);
            check(tag, "cfg_err", cfg_err, e_err);
            // advance model to the next edge
            if (!rst_n) begin
                m_st = 0; m_pos = 0;
            end else if (m_st != 1 || m_pos == ref_len(m_rate) - 1) begin
                m_rate = int'(rate_sel);
                m_pos  = 0;
                if (m_rate > 4) begin
                    m_st = 2; m_dsp = 0; m_err = 1;
                end else begin
                    m_st  = 1;
                    m_err = ref_illegal(m_rate, dsp_sel, int'(wlen_sel));
                    m_dsp = dsp_sel && !m_err;
                end
            end else begin
                m_pos++;
            end
        end
    end

    task automatic hold(input int r, input bit d, input int w, input int cyc);
        @(posedge mclk); #2;
        rate_sel = 3'(r); dsp_sel = d; wlen_sel = 2'(w);
        repeat (cyc - 1) @(posedge mclk);
    endtask

    initial begin
        repeat (3) @(posedge mclk);
        #2 rst_n = 1'b1;
        // R2 R3 R6: each rate, DSP off, two frames
        for (int r = 0; r < 5; r++) hold(r, 0, 2, 2 * ref_len(r) + 3);
        // R4 R7: legal DSP at every rate
        for (int r = 0; r < 5; r++) hold(r, 1, 0, 2 * ref_len(r));
        // R5: illegal pairs and their legal neighbours
        hold(0, 1, 1, 300); hold(0, 1, 2, 300); hold(0, 1, 3, 300);
        hold(1, 1, 3, 400); hold(1, 1, 2, 400); hold(1, 0, 3, 400);
        // R8: reserved codes, including a one-cycle pulse
        hold(5, 0, 0, 20); hold(6, 1, 1, 20); hold(7, 0, 0, 1);
        hold(2, 0, 0, 300); hold(7, 1, 3, 1); hold(6, 0, 0, 5); hold(1, 1, 0, 500);
        // R9: mid-frame changes, including the cycle before the last
        hold(3, 0, 0, 100); hold(0, 1, 0, 283); hold(4, 0, 0, 600);
        // random mix
        for (int i = 0; i < 60; i++)
            hold($urandom % 8, $urandom % 2, $urandom % 4, 1 + $urandom % 600);
        @(posedge mclk); #2 rst_n = 1'b0;
        repeat (3) @(posedge mclk);
        #2 rst_n = 1'b1;
        hold(1, 0, 0, 400);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (150000) @(posedge mclk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("[TB] FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule